// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake

This block is a watchdog that runs from its own slow clock, apart from the processor clock, so it keeps counting if the processor clock stops. A static configuration input turns it on. While it is on, an up-counter advances on every watchdog clock. When the counter wraps, that is a time-out. If the device is awake, the time-out raises a device reset request. If the device is asleep, the time-out raises a wake-up pulse and no reset.

Software keeps the watchdog from expiring by pulsing a clear input in the processor clock domain. The pulse crosses into the watchdog domain through a toggle-and-synchronizer path and restarts the count. An active-low flag goes to 0 when a watchdog time-out causes a reset or a wake. A watchdog-domain reset or a clear command sets the flag back to 1. All outputs belong to the watchdog clock domain.

Top module: `wdt_sleepwake`

## Requirements
- R1: After the watchdog-domain reset, rst_req_o and wake_o are 0 and to_n_o is 1.
- R2: With cfg_enable at 0, neither rst_req_o nor wake_o ever goes high.
- R3: With cfg_enable at 1, no clear and sleep_req low, rst_req_o first rises 2^CNT_W watchdog clocks after reset release, within a latency of a few cycles.
- R4: Each reset request holds rst_req_o high for exactly RST_HOLD consecutive watchdog clocks (default 2).
- R5: A time-out while sleep_req is high gives a wake_o pulse exactly one watchdog clock wide and no reset request.
- R6: A one-cycle clr_pulse in the processor domain restarts the counter within three watchdog clocks. Clears repeated at intervals shorter than the time-out period prevent every time-out.
- R7: After a time-out the counter restarts from zero, so successive time-outs without a clear are exactly 2^CNT_W watchdog clocks apart.
- R8: to_n_o drops to 0 in the same cycle that a time-out raises rst_req_o or wake_o.
- R9: to_n_o returns to 1 after a clear command or a watchdog-domain reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | Processor clock |
| rst_sys | input | 1 | Synchronous active-high reset, processor domain |
| clk_wdt | input | 1 | Independent watchdog clock |
| rst_wdt | input | 1 | Synchronous active-high power-on reset, watchdog domain |
| cfg_enable | input | 1 | Static enable; the erased default is 1 |
| clr_pulse | input | 1 | One-cycle clear command, processor domain |
| sleep_req | input | 1 | Sleep level, processor domain |
| rst_req_o | output | 1 | Device reset request, held RST_HOLD watchdog clocks |
| wake_o | output | 1 | One-cycle wake-up request |
| to_n_o | output | 1 | Active-low flag: 0 means the last reset or wake came from a time-out |

## Verification
The hardest case to reach from the ports is a clear that lands just before the counter wraps. The request has to cross into the other clock domain and zero the counter before the wrap. The bench first lets the counter run for most of a period, then issues a single clear in the processor domain. It checks that the first reset request is delayed by one full period measured from the clear. It also times two time-outs back to back to confirm that the counter restarts from zero. All of these checks use sampling points counted on the watchdog clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Outcome of one time-out decision
    typedef struct packed {
        logic fire_reset;
        logic fire_wake;
    } wdt_evt_t;

    // Counter value at which the next increment wraps
    function automatic logic [31:0] wrap_value(input int unsigned width);
        return (32'd1 << width) - 32'd1;
    endfunction

    // Classify a time-out against the sleep level
    function automatic wdt_evt_t decide(input logic tmo, input logic asleep);
        wdt_evt_t e;
        e.fire_reset = tmo & ~asleep;
        e.fire_wake  = tmo &  asleep;
        return e;
    endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wdt_clr_xfer.sv
module wdt_clr_xfer (
    input  logic clk_src,
    input  logic rst_src,
    input  logic pulse_src,
    input  logic clk_dst,
    input  logic rst_dst,
    output logic pulse_dst
);
    logic tgl_src;
    logic tgl_sync;
    logic tgl_seen;

    always_ff @(posedge clk_src) begin
        if (rst_src)        tgl_src <= 1'b0;
        else if (pulse_src) tgl_src <= ~tgl_src;
    end

    wdt_sync #(.STAGES(2)) u_tsync (
        .clk (clk_dst),
        .rst (rst_dst),
        .d   (tgl_src),
        .q   (tgl_sync)
    );

    always_ff @(posedge clk_dst) begin
        if (rst_dst) tgl_seen <= 1'b0;
        else         tgl_seen <= tgl_sync;
    end

    assign pulse_dst = tgl_sync ^ tgl_seen;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic clear,
    output logic timeout
);
    import wdt_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(wrap_value(CNT_W));

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable || clear) begin
            cnt     <= '0;
            timeout <= 1'b0;
        end else if (cnt == LAST) begin
            cnt     <= '0;
            timeout <= 1'b1;
        end else begin
            cnt     <= cnt + 1'b1;
            timeout <= 1'b0;
        end
    end
endmodule

// File: rtl/wdt_event.sv
module wdt_event #(
    parameter int RST_HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic timeout,
    input  logic asleep,
    input  logic clear,
    output logic rst_req,
    output logic wake,
    output logic to_n
);
    import wdt_pkg::*;

    localparam int HW = $clog2(RST_HOLD + 1);

    wdt_evt_t        evt;
    logic [HW-1:0]   hold_cnt;

    assign evt = decide(timeout, asleep);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            wake     <= 1'b0;
            to_n     <= 1'b1;
        end else begin
            wake <= evt.fire_wake;
            if (evt.fire_reset)     hold_cnt <= HW'(RST_HOLD);
            else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1'b1;
            if (evt.fire_reset || evt.fire_wake) to_n <= 1'b0;
            else if (clear)                      to_n <= 1'b1;
        end
    end

    assign rst_req = (hold_cnt != '0);
endmodule

// File: rtl/wdt_sleepwake.sv
module wdt_sleepwake #(
    parameter int CNT_W    = 8,
    parameter int RST_HOLD = 2
) (
    input  logic clk_sys,
    input  logic rst_sys,
    input  logic clk_wdt,
    input  logic rst_wdt,
    input  logic cfg_enable,
    input  logic clr_pulse,
    input  logic sleep_req,
    output logic rst_req_o,
    output logic wake_o,
    output logic to_n_o
);
    logic clr_w;
    logic sleep_w;
    logic tmo;

    wdt_clr_xfer u_clr (
        .clk_src   (clk_sys),
        .rst_src   (rst_sys),
        .pulse_src (clr_pulse),
        .clk_dst   (clk_wdt),
        .rst_dst   (rst_wdt),
        .pulse_dst (clr_w)
    );

    wdt_sync #(.STAGES(2)) u_slp (
        .clk (clk_wdt),
        .rst (rst_wdt),
        .d   (sleep_req),
        .q   (sleep_w)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk_wdt),
        .rst     (rst_wdt),
        .enable  (cfg_enable),
        .clear   (clr_w),
        .timeout (tmo)
    );

    wdt_event #(.RST_HOLD(RST_HOLD)) u_evt (
        .clk     (clk_wdt),
        .rst     (rst_wdt),
        .timeout (tmo),
        .asleep  (sleep_w),
        .clear   (clr_w),
        .rst_req (rst_req_o),
        .wake    (wake_o),
        .to_n    (to_n_o)
    );
endmodule

// File: rtl/wdt_sleepwake_chk.sv
module wdt_sleepwake_chk (
    input logic clk_wdt,
    input logic rst_wdt,
    input logic cfg_enable,
    input logic rst_req_o,
    input logic wake_o,
    input logic to_n_o
);
    // R5
    excl_evt_chk: assert property (@(posedge clk_wdt) disable iff (rst_wdt)
        !(rst_req_o && wake_o));

    // R5
    wake_single_chk: assert property (@(posedge clk_wdt) disable iff (rst_wdt)
        wake_o |=> !wake_o);

    // R4
    rst_hold_chk: assert property (@(posedge clk_wdt) disable iff (rst_wdt)
        $rose(rst_req_o) |=> rst_req_o);

    // R2
    disabled_quiet_chk: assert property (@(posedge clk_wdt) disable iff (rst_wdt)
        !cfg_enable |-> (!rst_req_o && !wake_o));

    // R8
    flag_cause_chk: assert property (@(posedge clk_wdt) disable iff (rst_wdt)
        $fell(to_n_o) |-> (rst_req_o || wake_o));
endmodule

bind wdt_sleepwake wdt_sleepwake_chk u_chk (
    .clk_wdt    (clk_wdt),
    .rst_wdt    (rst_wdt),
    .cfg_enable (cfg_enable),
    .rst_req_o  (rst_req_o),
    .wake_o     (wake_o),
    .to_n_o     (to_n_o)
);

// File: tb/test_wdt_sleepwake.sv
`timescale 1ns/1ps
module test_wdt_sleepwake;
    localparam int W    = 6;
    localparam int HOLD = 2;
    localparam int PER  = 1 << W;

    logic clk_sys = 0, clk_wdt = 0;
    logic rst_sys = 1, rst_wdt = 1;
    logic cfg_enable = 1, clr_pulse = 0, sleep_req = 0;
    logic rst_req_o, wake_o, to_n_o;

    int checks = 0, errors = 0;
    int rises, first_rise, second_rise, hi_max, hi_run, wakes, wake_hi;

    always #2  clk_sys = ~clk_sys;
    always #10 clk_wdt = ~clk_wdt;

    wdt_sleepwake #(.CNT_W(W), .RST_HOLD(HOLD)) i_wdt_sleepwake (
        .clk_sys(clk_sys), .rst_sys(rst_sys), .clk_wdt(clk_wdt), .rst_wdt(rst_wdt),
        .cfg_enable(cfg_enable), .clr_pulse(clr_pulse), .sleep_req(sleep_req),
        .rst_req_o(rst_req_o), .wake_o(wake_o), .to_n_o(to_n_o)
    );

    // fields: en, sleep, clear interval[3:0], expect reset, expect wake
    localparam logic [7:0] VEC [6] = '{
        {1'b1, 1'b0, 4'd0,  1'b1, 1'b0},
        {1'b1, 1'b1, 4'd0,  1'b0, 1'b1},
        {1'b0, 1'b0, 4'd0,  1'b0, 1'b0},
        {1'b0, 1'b1, 4'd0,  1'b0, 1'b0},
        {1'b1, 1'b0, 4'd10, 1'b0, 1'b0},
        {1'b1, 1'b1, 4'd15, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic en, input logic slp);
        @(negedge clk_wdt);
        rst_wdt = 1; rst_sys = 1; cfg_enable = en; sleep_req = slp;
        repeat (3) @(negedge clk_wdt);
        rst_wdt = 0; rst_sys = 0;
    endtask

    task automatic send_clear();
        @(negedge clk_sys); clr_pulse = 1;
        @(negedge clk_sys); clr_pulse = 0;
    endtask

    task automatic run(input int n, input int clr_every);
        logic prev = 0;
        rises = 0; first_rise = -1; second_rise = -1;
        hi_max = 0; hi_run = 0; wakes = 0; wake_hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk_wdt);
            if (rst_req_o) begin
                hi_run++;
                if (!prev) begin
                    rises++;
                    if (first_rise < 0) first_rise = i;
                    else if (second_rise < 0) second_rise = i;
                end
            end else hi_run = 0;
            if (hi_run > hi_max) hi_max = hi_run;
            if (wake_o) begin
                wakes++;
                wake_hi = wake_hi + 1;
            end
            prev = rst_req_o;
            if (clr_every > 0 && (i % clr_every) == clr_every - 1) send_clear();
        end
    endtask

    initial begin
        #(4 * 190000);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset(1'b1, 1'b0);
        @(negedge clk_wdt);
        chk(rst_req_o == 0, "R1 rst_req", rst_req_o, 0);
        chk(wake_o == 0, "R1 wake", wake_o, 0);
        chk(to_n_o == 1, "R1 to_n", to_n_o, 1);

        // table of vectors: R2 R3 R5 R6 R8
        foreach (VEC[k]) begin
            logic en, slp, er, ew;
            int ce;
            en = VEC[k][7]; slp = VEC[k][6]; ce = int'(VEC[k][5:2]);
            er = VEC[k][1]; ew = VEC[k][0];
            do_reset(en, slp);
            run(100, ce);
            chk(rises == int'(er), $sformatf("R2/R3/R6 vec%0d resets", k), rises, int'(er));
            chk(wakes == int'(ew), $sformatf("R5/R6 vec%0d wakes", k), wakes, int'(ew));
            chk(to_n_o == !(er || ew), $sformatf("R8 vec%0d to_n", k), to_n_o, !(er || ew));
            if (er) begin
                chk(first_rise >= PER - 2 && first_rise <= PER + 4, "R3 time-out cycle",
                    first_rise, PER);
                chk(hi_max == HOLD, "R4 hold width", hi_max, HOLD);
            end
            if (ew) chk(rises == 0 && wake_hi == 1, "R5 wake width", wake_hi, 1);
        end

        // R7 restart from zero: two time-outs exactly one period apart
        do_reset(1'b1, 1'b0);
        run(2 * PER + 12, 0);
        chk(rises == 2, "R7 two time-outs", rises, 2);
        chk(second_rise - first_rise == PER, "R7 spacing", second_rise - first_rise, PER);

        // R9 clear sets flag back to 1
        chk(to_n_o == 0, "R8 flag after reset event", to_n_o, 0);
        send_clear();
        repeat (5) @(negedge clk_wdt);
        chk(to_n_o == 1, "R9 flag after clear", to_n_o, 1);

        // R6 clear just before wrap pushes time-out one period past the clear
        do_reset(1'b1, 1'b0);
        run(PER - 9, 0);
        chk(rises == 0, "R6 no early time-out", rises, 0);
        send_clear();
        run(PER + 12, 0);
        chk(first_rise >= PER - 4 && first_rise <= PER + 4, "R6 delayed time-out",
            first_rise, PER);

        // R9 wake flag cleared by watchdog reset
        do_reset(1'b1, 1'b1);
        run(PER + 8, 0);
        chk(to_n_o == 0, "R8 flag after wake", to_n_o, 0);
        do_reset(1'b1, 1'b1);
        @(negedge clk_wdt);
        chk(to_n_o == 1, "R9 flag after reset", to_n_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule